// File: doc/BRIEF.md
# Parameterised Synchronous Up-Counter with Logarithmic Carry Tree

This block is an n-bit synchronous binary up-counter built from toggle logic. On each enabled clock a bit flips when the enable and every bit below it are high. The per-bit toggle conditions are not formed by a chain of AND gates. A parallel-prefix AND tree, like the carry lookahead in an adder, forms them in about log2(n) gate levels. The same tree also yields the terminal-count flag for the free-running case.

A count-enable input gates all counting. A terminal-count output goes high when the count sits at its last value while enabled. That output can drive the enable of a following stage, so counters can be cascaded. A synchronous clear and a parallel load are available. A build-time mode selects how the count ends. In free mode it wraps at all ones. In clear mode it returns to zero after MODULUS-1. In reload mode it loads a fixed start value after MODULUS-1. The two early-wrap modes give non-power-of-two cycle lengths.

Top module: `prefix_counter`

## Requirements
- R1: While `rst_n` is low, `count` is zero and `term_cnt` is low.
- R2: With `clear`, `load` and `cnt_en` all low, `count` keeps its value at the clock edge.
- R3: With `cnt_en` high, `clear` and `load` low, and `count` not at the terminal value, `count` becomes `count`+1 at the clock edge.
- R4: `term_cnt` is high exactly when `cnt_en` is high and `count` equals the terminal value. The terminal value is all ones in free mode and MODULUS-1 in the clear and reload modes.
- R5: In free mode (MODE = WRAP_FREE), an enabled edge at all ones gives zero.
- R6: In clear mode (MODE = WRAP_CLEAR), an enabled edge at MODULUS-1 gives zero.
- R7: In reload mode (MODE = WRAP_RELOAD), an enabled edge at MODULUS-1 gives RELOAD_VALUE.
- R8: A high `clear` sets `count` to zero at the edge, whatever `load` and `cnt_en` are.
- R9: A high `load` with `clear` low sets `count` to `load_value` at the edge, whatever `cnt_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear to zero, highest priority |
| load | input | 1 | Synchronous parallel load |
| cnt_en | input | 1 | Count enable |
| load_value | input | WIDTH | Value taken on load |
| count | output | WIDTH | Current count |
| term_cnt | output | 1 | Terminal count, qualified by enable |

## Verification
In the clear and reload modes, the assertions assume that software never loads a value above MODULUS-1. In reload mode they also assume RELOAD_VALUE lies below MODULUS-1. Under those conditions the count never leaves the range 0 to MODULUS-1. To keep within this, the stimulus draws the load value for the small counters from 0 to 11, with MODULUS at 12. The 8-bit free-running instance takes any load value. Enable, load and clear change at random on each cycle, so clear can meet load and load can meet a wrap on the same edge.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    WRAP_FREE   = 2'd0,
    WRAP_CLEAR  = 2'd1,
    WRAP_RELOAD = 2'd2
  } wrap_mode_e;
endpackage

// File: rtl/pc_prefix_and.sv
// Parallel-prefix AND (Kogge-Stone shape): pre[i] = AND of in_bits[0..i].
module pc_prefix_and #(
  parameter int N = 9
) (
  input  logic [N-1:0] in_bits,
  output logic [N-1:0] pre
);
  localparam int LVL = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] stg [LVL+1];

  always_comb begin
    stg[0] = in_bits;
    for (int l = 0; l < LVL; l++) begin
      for (int i = 0; i < N; i++) begin
        if (i >= (1 << l)) stg[l+1][i] = stg[l][i] & stg[l][i - (1 << l)];
        else               stg[l+1][i] = stg[l][i];
      end
    end
  end

  assign pre = stg[LVL];
endmodule

// File: rtl/pc_term_detect.sv
// Terminal value comparator used by the early-wrap modes.
module pc_term_detect #(
  parameter int               WIDTH    = 4,
  parameter logic [WIDTH-1:0] TERM_VAL = '1
) (
  input  logic [WIDTH-1:0] count,
  input  logic             en,
  output logic             hit
);
  assign hit = en & (count == TERM_VAL);
endmodule

// File: rtl/prefix_counter.sv
module prefix_counter #(
  parameter int                 WIDTH        = 8,
  parameter pc_pkg::wrap_mode_e MODE         = pc_pkg::WRAP_FREE,
  parameter int                 MODULUS      = 12,
  parameter int                 RELOAD_VALUE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic             cnt_en,
  input  logic [WIDTH-1:0] load_value,
  output logic [WIDTH-1:0] count,
  output logic             term_cnt
);
  localparam int               NPRE     = WIDTH + 1;
  localparam logic [WIDTH-1:0] TERM_VAL = (MODE == pc_pkg::WRAP_FREE) ? {WIDTH{1'b1}}
                                                                       : WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] WRAP_VAL = (MODE == pc_pkg::WRAP_RELOAD) ? WIDTH'(RELOAD_VALUE)
                                                                         : '0;

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [NPRE-1:0]  pre_in, pre_out;
  logic [WIDTH-1:0] tog;
  logic             term;
  logic             early_wrap;
  logic             cnt_we;

  // Prefix inputs: slot 0 is the enable, slot k is bit k-1 of the count.
  assign pre_in = {cnt_q, cnt_en};

  pc_prefix_and #(.N(NPRE)) u_prefix (
    .in_bits (pre_in),
    .pre     (pre_out)
  );

  assign tog = pre_out[WIDTH-1:0];

  generate
    if (MODE == pc_pkg::WRAP_FREE) begin : g_free
      assign term       = pre_out[WIDTH];
      assign early_wrap = 1'b0;
    end else begin : g_early
      pc_term_detect #(.WIDTH(WIDTH), .TERM_VAL(TERM_VAL)) u_term (
        .count (cnt_q),
        .en    (cnt_en),
        .hit   (term)
      );
      assign early_wrap = term;
    end
  endgenerate

  always_comb begin
    if (clear)           cnt_d = '0;
    else if (load)       cnt_d = load_value;
    else if (early_wrap) cnt_d = WRAP_VAL;
    else                 cnt_d = cnt_q ^ tog;
  end

  assign cnt_we = clear | load | cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign count    = cnt_q;
  assign term_cnt = term;
endmodule

// File: rtl/pc_checks.sv
module pc_checks #(
  parameter int                 WIDTH    = 8,
  parameter pc_pkg::wrap_mode_e MODE     = pc_pkg::WRAP_FREE,
  parameter logic [WIDTH-1:0]   TERM_VAL = '1,
  parameter logic [WIDTH-1:0]   WRAP_VAL = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             load,
  input logic             cnt_en,
  input logic [WIDTH-1:0] load_value,
  input logic [WIDTH-1:0] count,
  input logic             term_cnt
);
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> (count == '0 && !term_cnt));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load && !cnt_en) |=> $stable(count));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load && cnt_en && count != TERM_VAL) |=> count == WIDTH'($past(count) + 1'b1));

  a_r4_tc_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> (cnt_en && count == TERM_VAL));

  a_r5_r6_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (term_cnt && !clear && !load) |=> count == WRAP_VAL);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0);

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> count == $past(load_value));

  generate
    if (MODE != pc_pkg::WRAP_FREE) begin : g_range
      a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TERM_VAL);
    end
  endgenerate
endmodule

bind prefix_counter pc_checks #(
  .WIDTH(WIDTH), .MODE(MODE), .TERM_VAL(TERM_VAL), .WRAP_VAL(WRAP_VAL)
) u_pc_checks (
  .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .cnt_en(cnt_en),
  .load_value(load_value), .count(count), .term_cnt(term_cnt)
);

// File: tb/test_prefix_counter.sv
module test_prefix_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, load = 1'b0, cnt_en = 1'b0;
  logic [7:0] lv8 = '0;
  logic [3:0] lv4 = '0;
  logic [7:0] c_free;
  logic [3:0] c_clr, c_rld;
  logic       t_free, t_clr, t_rld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Per-instance reference state: 0 = free 8-bit, 1 = clear mod 12, 2 = reload mod 12 from 3
  int    mcount [3];
  string mtag   [3];
  int    mterm  [3] = '{255, 11, 11};
  int    mwrap  [3] = '{0, 0, 3};
  string wtag   [3] = '{"R5", "R6", "R7"};
  int    mmask  [3] = '{255, 15, 15};

  always #2.5 clk = ~clk;

  prefix_counter #(.WIDTH(8)) i_prefix_counter (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .cnt_en(cnt_en),
    .load_value(lv8), .count(c_free), .term_cnt(t_free));

  prefix_counter #(.WIDTH(4), .MODE(pc_pkg::WRAP_CLEAR), .MODULUS(12)) i_prefix_counter_clr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .cnt_en(cnt_en),
    .load_value(lv4), .count(c_clr), .term_cnt(t_clr));

  prefix_counter #(.WIDTH(4), .MODE(pc_pkg::WRAP_RELOAD), .MODULUS(12), .RELOAD_VALUE(3))
    i_prefix_counter_rld (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .cnt_en(cnt_en),
    .load_value(lv4), .count(c_rld), .term_cnt(t_rld));

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_n) begin
        mcount[k] = 0; mtag[k] = "R1";
      end else if (clear) begin
        mcount[k] = 0; mtag[k] = "R8";
      end else if (load) begin
        mcount[k] = (k == 0) ? int'(lv8) : int'(lv4); mtag[k] = "R9";
      end else if (cnt_en) begin
        if (mcount[k] == mterm[k]) begin
          mcount[k] = mwrap[k]; mtag[k] = wtag[k];
        end else begin
          mcount[k] = (mcount[k] + 1) & mmask[k]; mtag[k] = "R3";
        end
      end else begin
        mtag[k] = "R2";
      end
    end
  end

  function automatic int act_count(int k);
    return (k == 0) ? int'(c_free) : (k == 1) ? int'(c_clr) : int'(c_rld);
  endfunction

  function automatic int act_term(int k);
    return (k == 0) ? int'(t_free) : (k == 1) ? int'(t_clr) : int'(t_rld);
  endfunction

  task automatic check_all();
    for (int k = 0; k < 3; k++) begin
      int exp_t;
      exp_t = (cnt_en && mcount[k] == mterm[k]) ? 1 : 0;
      checks++;
      if (act_count(k) != mcount[k]) begin
        errors++;
        $display("FAIL %s inst%0d count actual %0d expected %0d", mtag[k], k, act_count(k), mcount[k]);
      end
      checks++;
      if (act_term(k) != exp_t) begin
        errors++;
        $display("FAIL R4 inst%0d term_cnt actual %0d expected %0d (count %0d)", k, act_term(k), exp_t, mcount[k]);
      end
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all();                         // R1: reset state
    rst_n = 1'b1;
    // Directed: free counting through several wraps (R3, R5, R6, R7)
    cnt_en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      check_all();
    end
    // Directed: R8 clear beats load, R9 load beats enable, R2 hold
    clear = 1'b1; load = 1'b1; lv8 = 8'd77; lv4 = 4'd9;
    @(negedge clk); check_all();
    clear = 1'b0;
    @(negedge clk); check_all();
    load = 1'b0; cnt_en = 1'b0;
    repeat (3) begin @(negedge clk); check_all(); end
    // Random mix of enable, load, clear
    for (int i = 0; i < 3000; i++) begin
      cnt_en = ($urandom_range(0, 3) != 0);
      load   = ($urandom_range(0, 15) == 0);
      clear  = ($urandom_range(0, 31) == 0);
      lv8    = 8'($urandom_range(0, 255));
      lv4    = 4'($urandom_range(0, 11));
      @(negedge clk);
      check_all();
    end
    // Asynchronous reset in the middle of a run (R1)
    rst_n = 1'b0;
    #1;
    check_all();
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule